// File: doc/BRIEF.md
# Real-Time Clock Control and Status Register

This block sits between a processor bus and the counting logic of a real-time clock. It exposes a 4-bit data path with an address, a read strobe and a write strobe. A write to the control address loads four control latches. These latches produce run/stop levels for the timekeeping chain and for the interrupt delay timer, a test-mode level, and a steering bit. A read of the same address returns two sticky status flags instead of the latches.

The steering bit decides which of two external registers the highest address reaches. One is the clock-setting register and the other is the interrupt configuration register. The block forwards write pulses and write data to the selected one, and it returns that register's contents on a read.

Two event pulses come in from the counters. The time-advance pulse sets a data-changed flag. The timer-timeout pulse sets an interrupt flag and pulls the active-low interrupt line. A read of the control address clears both flags and releases the line. If an event arrives in the same cycle as that read, the read returns the value from before the event and the flag stays set for the next read. All outputs are registered, and read data appears one cycle after the read strobe.

Top module: `rtc_ctrl_stat`

## Requirements
- R1: A write to address 0 loads the control latches from the data bus. Bit 3 sets test mode (`test_mode`). Bit 2 is clock stop (1 stops, `clk_run` low). Bit 1 is the steering bit. Bit 0 is interrupt-timer stop (1 stops, `irq_run` low). The outputs take the new values in the cycle after the write.
- R2: A read of address 0 returns the data-changed flag on bit 3 and the interrupt flag on bit 0, with bits 2 and 1 at 0. `rdata` is valid in the cycle after the read strobe.
- R3: While the clock stop latch is 1, `clk_run` is 0 and `tenths_clr` is 1, which holds the tenths counter at zero. Writing 0 to the latch gives `clk_run` 1 and `tenths_clr` 0.
- R4: Address 15 reaches the clock-setting register when the steering bit is 0 and the interrupt configuration register when it is 1. A write there gives a one-cycle pulse on `set_wr` or on `icfg_wr`, with the data on `ext_wdata`. A read there returns `set_rdata` or `icfg_rdata`.
- R5: A `tick` pulse sets the data-changed flag. Only a read of address 0 clears it. Writes to any address and reads of other addresses leave it unchanged.
- R6: A `timeout` pulse sets the interrupt flag and drives `irq_n` low in the following cycle. One read of address 0 clears the flag and returns `irq_n` to 1.
- R7: When `tick` or `timeout` arrives in the same cycle as a read of address 0, the read returns the flag value from before the event, and the flag stays set for the next read.
- R8: Writing 0 to address 0 gives normal mode, a running clock, the clock-setting register on address 15, and a running interrupt timer.
- R9: After reset, the clock and the interrupt timer are stopped, test mode is off, the steering bit is 0, both flags are clear and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data, valid the cycle after `rd_en` |
| tick | input | 1 | Time-advance pulse from the timekeeping chain |
| timeout | input | 1 | Timeout pulse from the interrupt timer |
| set_rdata | input | 4 | Contents of the clock-setting register |
| icfg_rdata | input | 4 | Contents of the interrupt configuration register |
| set_wr | output | 1 | Write pulse to the clock-setting register |
| icfg_wr | output | 1 | Write pulse to the interrupt configuration register |
| ext_wdata | output | 4 | Data for the external register writes |
| clk_run | output | 1 | Timekeeping enable |
| tenths_clr | output | 1 | Holds the tenths counter at zero |
| irq_run | output | 1 | Interrupt timer enable |
| test_mode | output | 1 | Test-mode level |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The bench checks several corner cases:

- **Read collisions.** An event pulse that lands in the same cycle as a control read must leave its flag set. A design that gives the clear priority would lose that event, and the second read would come back empty.
- **Clearing scope.** The bench confirms that writes, including an all-zero control write, and reads of the high and unused addresses keep the data-changed flag. A decoder that clears on any access, or on any write to address 0, would drop the flag.
- **Steering.** The steering test toggles the selection bit between accesses to address 15. A mux that picks the wrong register, or that pulses both write strobes, shows up in the read data and in the captured pulses.
- **Reset and zero writes.** The reset-state and all-zero-write checks catch inverted run/stop polarities.

// File: rtl/rtc_cs_pkg.sv
package rtc_cs_pkg;
  localparam int DW = 4;

  // Field order follows the bus bit positions 3..0
  typedef struct packed {
    logic test;
    logic clk_stop;
    logic sel_icfg;
    logic irq_stop;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{test: 1'b0, clk_stop: 1'b1, sel_icfg: 1'b0, irq_stop: 1'b1};

  localparam int B_DCHG = 3;
  localparam int B_IFLG = 0;
endpackage

// File: rtl/rtc_cs_latch.sv
module rtc_cs_latch
  import rtc_cs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output ctrl_t         ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= CTRL_RST;
    else if (we) ctrl_q <= ctrl_t'(wdata);
  end
endmodule

// File: rtl/rtc_cs_flag.sv
module rtc_cs_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // An event in the clearing cycle wins, so it is not lost
  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= set_i | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/rtc_cs_port.sv
module rtc_cs_port
  import rtc_cs_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              sel_icfg,
  input  logic              dchg,
  input  logic              iflg,
  input  logic [DW-1:0]     set_rdata,
  input  logic [DW-1:0]     icfg_rdata,
  output logic [DW-1:0]     rdata,
  output logic              set_wr,
  output logic              icfg_wr,
  output logic [DW-1:0]     ext_wdata
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STEER = {ADDR_W{1'b1}};

  logic          hit_ctrl, hit_steer;
  logic [DW-1:0] rd_sel;

  assign hit_ctrl  = (addr == A_CTRL);
  assign hit_steer = (addr == A_STEER);

  always_comb begin
    rd_sel = '0;
    if (hit_ctrl) begin
      rd_sel[B_DCHG] = dchg;
      rd_sel[B_IFLG] = iflg;
    end else if (hit_steer) begin
      rd_sel = sel_icfg ? icfg_rdata : set_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      set_wr    <= 1'b0;
      icfg_wr   <= 1'b0;
      ext_wdata <= '0;
    end else begin
      if (rd_en) rdata <= rd_sel;
      set_wr  <= wr_en & hit_steer & ~sel_icfg;
      icfg_wr <= wr_en & hit_steer &  sel_icfg;
      if (wr_en & hit_steer) ext_wdata <= wdata;
    end
  end
endmodule

// File: rtl/rtc_ctrl_stat.sv
module rtc_ctrl_stat
  import rtc_cs_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              tick,
  input  logic              timeout,
  input  logic [DW-1:0]     set_rdata,
  input  logic [DW-1:0]     icfg_rdata,
  output logic              set_wr,
  output logic              icfg_wr,
  output logic [DW-1:0]     ext_wdata,
  output logic              clk_run,
  output logic              tenths_clr,
  output logic              irq_run,
  output logic              test_mode,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

  ctrl_t ctrl_q;
  logic  ctrl_hit, ctrl_rd, dchg_q, iflg_q;

  assign ctrl_hit = (addr == A_CTRL);
  assign ctrl_rd  = rd_en & ctrl_hit;

  rtc_cs_latch u_latch (
    .clk(clk), .rst(rst), .we(wr_en & ctrl_hit), .wdata(wdata), .ctrl_q(ctrl_q)
  );

  rtc_cs_flag u_dchg (
    .clk(clk), .rst(rst), .set_i(tick), .clr_i(ctrl_rd), .flag_o(dchg_q)
  );

  rtc_cs_flag u_iflg (
    .clk(clk), .rst(rst), .set_i(timeout), .clr_i(ctrl_rd), .flag_o(iflg_q)
  );

  rtc_cs_port #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_port (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .sel_icfg(ctrl_q.sel_icfg), .dchg(dchg_q), .iflg(iflg_q),
    .set_rdata(set_rdata), .icfg_rdata(icfg_rdata), .rdata(rdata),
    .set_wr(set_wr), .icfg_wr(icfg_wr), .ext_wdata(ext_wdata)
  );

  assign clk_run    = ~ctrl_q.clk_stop;
  assign tenths_clr =  ctrl_q.clk_stop;
  assign irq_run    = ~ctrl_q.irq_stop;
  assign test_mode  =  ctrl_q.test;
  assign irq_n      = ~iflg_q;
endmodule

// File: rtl/rtc_ctrl_stat_chk.sv
module rtc_ctrl_stat_chk #(
  parameter int ADDR_W = 4,
  parameter int CTRL_ADDR = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [3:0]        wdata,
  input logic [3:0]        rdata,
  input logic              tick,
  input logic              timeout,
  input logic              set_wr,
  input logic              icfg_wr,
  input logic              clk_run,
  input logic              test_mode,
  input logic              irq_n,
  input logic              sel_icfg,
  input logic              dchg_q
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STEER = {ADDR_W{1'b1}};

  p_ctrl_write_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTRL) |=> (test_mode == $past(wdata[3]) && clk_run == !$past(wdata[2])));

  p_rd_zero_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_CTRL) |=> (rdata[2:1] == 2'b00));

  p_steer_set_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_STEER && !sel_icfg) |=> (set_wr && !icfg_wr));

  p_steer_icfg_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_STEER && sel_icfg) |=> (icfg_wr && !set_wr));

  p_dchg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!(rd_en && addr == A_CTRL) && !tick) |=> $stable(dchg_q));

  p_irq_low_r6: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !irq_n);

  p_irq_release_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_CTRL && !timeout) |=> irq_n);

  p_keep_event_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_CTRL && tick) |=> dchg_q);
endmodule

bind rtc_ctrl_stat rtc_ctrl_stat_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) i_chk (
  .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .tick(tick), .timeout(timeout), .set_wr(set_wr), .icfg_wr(icfg_wr),
  .clk_run(clk_run), .test_mode(test_mode), .irq_n(irq_n),
  .sel_icfg(ctrl_q.sel_icfg), .dchg_q(dchg_q)
);

// File: tb/test_rtc_ctrl_stat.sv
module test_rtc_ctrl_stat;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] addr;
  logic       rd_en, wr_en, tick, timeout;
  logic [3:0] wdata, rdata, ext_wdata;
  logic [3:0] set_rdata  = 4'h5;
  logic [3:0] icfg_rdata = 4'hA;
  logic       set_wr, icfg_wr, clk_run, tenths_clr, irq_run, test_mode, irq_n;

  int n_chk = 0;
  int n_fail = 0;
  logic seen_set, seen_icfg;
  logic [3:0] seen_wd;

  always #(PERIOD/2) clk = ~clk;

  rtc_ctrl_stat i_rtc_ctrl_stat (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .tick(tick), .timeout(timeout), .set_rdata(set_rdata),
    .icfg_rdata(icfg_rdata), .set_wr(set_wr), .icfg_wr(icfg_wr), .ext_wdata(ext_wdata),
    .clk_run(clk_run), .tenths_clr(tenths_clr), .irq_run(irq_run),
    .test_mode(test_mode), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    seen_set = set_wr; seen_icfg = icfg_wr; seen_wd = ext_wdata;
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, input logic ev_tick, input logic ev_to,
                         output logic [3:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1; tick = ev_tick; timeout = ev_to;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0; tick = 1'b0; timeout = 1'b0;
  endtask

  task automatic pulse(input logic ev_tick, input logic ev_to);
    @(negedge clk);
    tick = ev_tick; timeout = ev_to;
    @(negedge clk);
    tick = 1'b0; timeout = 1'b0;
  endtask

  // Control outputs packed as {test, clk_run, irq_run, tenths_clr}
  function automatic logic [7:0] ctl_vec();
    return {4'h0, test_mode, clk_run, irq_run, tenths_clr};
  endfunction

  task automatic t_reset();
    logic [3:0] d;
    check("R9 control outputs", ctl_vec(), 8'h01);
    check("R9 irq_n", {7'h0, irq_n}, 8'h01);
    do_read(4'd0, 1'b0, 1'b0, d);
    check("R9 R2 flags clear", {4'h0, d}, 8'h00);
    do_read(4'd15, 1'b0, 1'b0, d);
    check("R9 steering selects clock-setting", {4'h0, d}, 8'h05);
  endtask

  task automatic t_ctrl_write();
    do_write(4'd0, 4'b1000);
    check("R1 test on, both running", ctl_vec(), 8'h0E);
    do_write(4'd0, 4'b0100);
    check("R3 clock stopped, tenths held", ctl_vec(), 8'h03);
    do_write(4'd0, 4'b0001);
    check("R1 R3 interrupt stopped, clock running", ctl_vec(), 8'h04);
    do_write(4'd0, 4'b0000);
    check("R8 all-zero write", ctl_vec(), 8'h06);
  endtask

  task automatic t_steer();
    logic [3:0] d;
    do_write(4'd15, 4'h3);
    check("R4 set_wr/icfg_wr/data sel=0", {2'b0, seen_set, seen_icfg, seen_wd}, 8'h23);
    do_read(4'd15, 1'b0, 1'b0, d);
    check("R4 read clock-setting", {4'h0, d}, 8'h05);
    do_write(4'd0, 4'b0010);
    do_write(4'd15, 4'hC);
    check("R4 set_wr/icfg_wr/data sel=1", {2'b0, seen_set, seen_icfg, seen_wd}, 8'h1C);
    do_read(4'd15, 1'b0, 1'b0, d);
    check("R4 read interrupt config", {4'h0, d}, 8'h0A);
    do_write(4'd0, 4'b0000);
    do_read(4'd15, 1'b0, 1'b0, d);
    check("R8 zero write reselects clock-setting", {4'h0, d}, 8'h05);
  endtask

  task automatic t_dchg();
    logic [3:0] d;
    pulse(1'b1, 1'b0);
    do_write(4'd0, 4'b0000);
    do_write(4'd15, 4'h1);
    do_read(4'd15, 1'b0, 1'b0, d);
    do_read(4'd5, 1'b0, 1'b0, d);
    check("R5 unused address reads zero", {4'h0, d}, 8'h00);
    do_read(4'd0, 1'b0, 1'b0, d);
    check("R5 R2 flag survives other accesses", {4'h0, d}, 8'h08);
    do_read(4'd0, 1'b0, 1'b0, d);
    check("R5 flag cleared by control read", {4'h0, d}, 8'h00);
  endtask

  task automatic t_irq();
    logic [3:0] d;
    pulse(1'b0, 1'b1);
    check("R6 irq_n low after timeout", {7'h0, irq_n}, 8'h00);
    do_read(4'd15, 1'b0, 1'b0, d);
    check("R6 irq_n held over other read", {7'h0, irq_n}, 8'h00);
    do_read(4'd0, 1'b0, 1'b0, d);
    check("R6 R2 interrupt flag read", {4'h0, d}, 8'h01);
    check("R6 irq_n released", {7'h0, irq_n}, 8'h01);
    do_read(4'd0, 1'b0, 1'b0, d);
    check("R6 flag cleared", {4'h0, d}, 8'h00);
  endtask

  task automatic t_collide();
    logic [3:0] d;
    do_read(4'd0, 1'b1, 1'b1, d);
    check("R7 colliding read returns old value", {4'h0, d}, 8'h00);
    check("R7 irq_n low after colliding timeout", {7'h0, irq_n}, 8'h00);
    do_read(4'd0, 1'b0, 1'b0, d);
    check("R7 both flags kept for next read", {4'h0, d}, 8'h09);
    pulse(1'b1, 1'b0);
    do_read(4'd0, 1'b1, 1'b0, d);
    check("R7 set flag read during new tick", {4'h0, d}, 8'h08);
    do_read(4'd0, 1'b0, 1'b0, d);
    check("R7 tick during read kept", {4'h0, d}, 8'h08);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; addr = '0; wdata = '0; rd_en = 1'b0; wr_en = 1'b0;
    tick = 1'b0; timeout = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl_write();
    t_steer();
    t_dchg();
    t_irq();
    t_collide();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule